// File: doc/BRIEF.md
# Per-Byte Software Acknowledge Controller

This block sits in the receive path of a two-wire serial interface and gives software the final say over the acknowledge bit of every received byte. It watches the clock line and counts the falling edges that close each data bit. When interactive acknowledge is switched on, the eighth edge makes it pull the clock line low and raise a flag. The bus then stays stretched until software has inspected the byte and made its choice.

Software answers by putting its choice on `ack_sel` and pulsing `flag_clr`, which stands for writing a one to the flag. The block drops the flag and drives the data line to the chosen level. It then keeps the clock line low for a programmable number of system clocks, so that the data setup time is honoured in either bus role. After that it frees the clock line and holds the data level until the acknowledge clock pulse has ended. An external detector supplies start and stop indications, and these frame the bit count.

Top module: `byte_ack_hold`

## Requirements
- R1: After reset, `scl_drive_low`, `sda_drive_low` and `ack_flag` are all 0.
- R2: With interactive mode latched on, the eighth counted falling edge of `scl_in` in a byte sets `ack_flag` and asserts `scl_drive_low`, both visible three clocks after `scl_in` falls. The first falling edge after a start indication closes the start and is not counted.
- R3: While `ack_flag` is 1, `scl_drive_low` stays 1 and `sda_drive_low` stays 0, however long software waits.
- R4: A `flag_clr` pulse while `ack_flag` is 1 has three effects. `ack_flag` is 0 on the next clock. From that clock, `sda_drive_low` is 1 if `ack_sel` was 0 (ACK) and 0 if it was 1 (NACK). `scl_drive_low` stays 1 for exactly `setup_cnt`+1 clocks from that clock, and is 0 after them.
- R5: Once the clock line is released, the data level is held until the next falling edge of `scl_in`, which ends the acknowledge pulse. The data line is then released and the bit count restarts, so the following byte stretches again.
- R6: A `flag_clr` pulse while `ack_flag` is 0 changes no output and leaves the next byte's stretch unaffected.
- R7: With interactive mode latched off, `scl_drive_low` and `ack_flag` never assert.
- R8: `mode_en` is taken in only while no transfer is open, that is after reset or a stop and up to and including the clock of a start. A change during a transfer first acts in the next transfer.
- R9: A start or stop indication clears the bit count. It also ends any stretch or acknowledge phase, so that the next clock shows all three outputs at 0. This holds even when `flag_clr` arrives in the same cycle.
- R10: The acknowledge level is captured at the clock that accepts `flag_clr`. Later changes of `ack_sel` do not alter `sda_drive_low` until the acknowledge phase ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Raw clock-line level from the bus |
| start_det | input | 1 | One-cycle start indication from the condition detector |
| stop_det | input | 1 | One-cycle stop indication from the condition detector |
| mode_en | input | 1 | Interactive acknowledge enable |
| ack_sel | input | 1 | Acknowledge choice: 0 = ACK (data low), 1 = NACK (data released) |
| flag_clr | input | 1 | Write-one pulse that clears the flag |
| setup_cnt | input | SETUP_W | Data setup time in system clocks |
| scl_drive_low | output | 1 | Open-drain enable pulling the clock line low |
| sda_drive_low | output | 1 | Open-drain enable pulling the data line low |
| ack_flag | output | 1 | Interrupt flag: a byte awaits its acknowledge decision |

## Verification
Two functions can fall in the same cycle: the software release of a stretched byte and the framing reset from a start or stop indication. The bench holds a byte stretched, then drives `flag_clr` and `stop_det` in one cycle. It expects the framing reset to win: all lines free and the flag down on the next clock, with no setup countdown started. A behavioural model running alongside the design judges this edge, and every other clock, on all three outputs. A second collision, a `mode_en` change during an open transfer, is judged by checking that the stretch appears only in the following transfer.

// File: rtl/byte_ack_pkg.sv
package byte_ack_pkg;

  // Phases of the per-byte acknowledge handshake.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // counting bits, lines free
    ST_HOLD  = 2'd1,  // clock stretched, waiting for software
    ST_SETUP = 2'd2,  // data level placed, setup countdown running
    ST_ACK   = 2'd3   // clock free, data level held through the ack pulse
  } hold_state_e;

  function automatic logic pulls_clock(hold_state_e s);
    return (s == ST_HOLD) || (s == ST_SETUP);
  endfunction

  function automatic logic pulls_data(hold_state_e s, logic nack);
    return ((s == ST_SETUP) || (s == ST_ACK)) && !nack;
  endfunction

endpackage

// File: rtl/scl_edge_sync.sv
module scl_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic fall_pulse
);
  logic [STAGES:0] tap;
  logic            prev_q;

  assign tap[0] = line_in;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap[i+1] <= 1'b1;
        else        tap[i+1] <= tap[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= tap[STAGES];
  end

  assign fall_pulse = prev_q & ~tap[STAGES];

  // An edge lasts one cycle only.
  p_fall_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_pulse |=> !fall_pulse);

endmodule

// File: rtl/byte_bit_counter.sv
module byte_bit_counter #(
  parameter int BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_fall,
  input  logic start_det,
  input  logic stop_det,
  output logic byte_end,
  output logic ack_end
);
  localparam int CW = $clog2(BITS + 1);
  localparam logic [CW-1:0] LAST_DATA = CW'(BITS - 1);
  localparam logic [CW-1:0] ACK_SLOT  = CW'(BITS);

  logic [CW-1:0] cnt_q;
  logic          skip_q;  // next fall closes a start, not a bit

  function automatic logic [CW-1:0] bump(logic [CW-1:0] c);
    return (c == ACK_SLOT) ? '0 : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      skip_q <= 1'b0;
    end else if (start_det) begin
      cnt_q  <= '0;
      skip_q <= 1'b1;
    end else if (stop_det) begin
      cnt_q  <= '0;
      skip_q <= 1'b0;
    end else if (scl_fall) begin
      if (skip_q) skip_q <= 1'b0;
      else        cnt_q  <= bump(cnt_q);
    end
  end

  assign byte_end = scl_fall && !skip_q && (cnt_q == LAST_DATA);
  assign ack_end  = scl_fall && !skip_q && (cnt_q == ACK_SLOT);

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ACK_SLOT);

  p_frame_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> (cnt_q == '0));

endmodule

// File: rtl/ack_stretch_fsm.sv
module ack_stretch_fsm
  import byte_ack_pkg::*;
#(
  parameter int SETUP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               byte_end,
  input  logic               ack_end,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic               mode_en,
  input  logic               ack_sel,
  input  logic               flag_clr,
  input  logic [SETUP_W-1:0] setup_cnt,
  output logic               scl_low,
  output logic               sda_low,
  output logic               flag
);
  hold_state_e        state_q;
  logic [SETUP_W-1:0] timer_q;
  logic               nack_q;
  logic               busy_q;
  logic               mode_q;
  logic               abort;

  function automatic logic [SETUP_W-1:0] tick(logic [SETUP_W-1:0] t);
    return (t == '0) ? '0 : t - 1'b1;
  endfunction

  assign abort = start_det | stop_det;

  // Transfer framing and mode capture outside transfers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      if (!busy_q) mode_q <= mode_en;
      if (start_det)     busy_q <= 1'b1;
      else if (stop_det) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      timer_q <= '0;
      nack_q  <= 1'b0;
    end else if (abort) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (byte_end && mode_q) state_q <= ST_HOLD;
        ST_HOLD:  if (flag_clr) begin
                    state_q <= ST_SETUP;
                    timer_q <= setup_cnt;
                    nack_q  <= ack_sel;
                  end
        ST_SETUP: if (timer_q == '0) state_q <= ST_ACK;
                  else               timer_q <= tick(timer_q);
        ST_ACK:   if (ack_end) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign scl_low = pulls_clock(state_q);
  assign sda_low = pulls_data(state_q, nack_q);
  assign flag    = (state_q == ST_HOLD);

  p_flag_needs_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> mode_q);

  p_hold_lines_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flag |-> (scl_low && !sda_low));

  p_clear_drops_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && flag_clr && !abort) |=> !flag);

  p_release_on_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP && timer_q == '0 && !abort) |=> (!scl_low && state_q == ST_ACK));

  p_ack_level_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACK && $past(state_q) == ST_ACK) |-> $stable(sda_low));

endmodule

// File: rtl/byte_ack_hold.sv
module byte_ack_hold #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_BITS   = 8,
  parameter int SETUP_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic               mode_en,
  input  logic               ack_sel,
  input  logic               flag_clr,
  input  logic [SETUP_W-1:0] setup_cnt,
  output logic               scl_drive_low,
  output logic               sda_drive_low,
  output logic               ack_flag
);
  logic scl_fall;
  logic byte_end;
  logic ack_end;

  scl_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_in    (scl_in),
    .fall_pulse (scl_fall)
  );

  byte_bit_counter #(.BITS(BYTE_BITS)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .byte_end  (byte_end),
    .ack_end   (ack_end)
  );

  ack_stretch_fsm #(.SETUP_W(SETUP_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_end  (byte_end),
    .ack_end   (ack_end),
    .start_det (start_det),
    .stop_det  (stop_det),
    .mode_en   (mode_en),
    .ack_sel   (ack_sel),
    .flag_clr  (flag_clr),
    .setup_cnt (setup_cnt),
    .scl_low   (scl_drive_low),
    .sda_low   (sda_drive_low),
    .flag      (ack_flag)
  );

  p_abort_frees_lines_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> (!scl_drive_low && !sda_drive_low && !ack_flag));

  p_no_edge_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_end && ack_end));

endmodule

// File: tb/byte_ack_hold_bench.sv
`timescale 1ns/1ps
module byte_ack_hold_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_mst = 1'b1;
  logic start_det = 1'b0, stop_det = 1'b0, mode_en = 1'b0;
  logic ack_sel = 1'b0, flag_clr = 1'b0;
  logic [7:0] setup_cnt = 8'd5;
  logic scl_drive_low, sda_drive_low, ack_flag;
  wire  scl_in = scl_mst & ~scl_drive_low;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 1'b0;
  int stretch_seen = 0;

  always #10 clk = ~clk;

  byte_ack_hold u_byte_ack_hold (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .start_det(start_det),
    .stop_det(stop_det), .mode_en(mode_en), .ack_sel(ack_sel),
    .flag_clr(flag_clr), .setup_cnt(setup_cnt), .scl_drive_low(scl_drive_low),
    .sda_drive_low(sda_drive_low), .ack_flag(ack_flag)
  );

  // Behavioural reference: line history list plus a phase number.
  int  hist[3] = '{1, 1, 1};    // newest first
  int  bits_seen = 0, phase = 0, wait_left = 0;
  bit  in_xfer = 0, live_mode = 0, eat_fall = 0, said_nack = 0;
  bit  fell, eighth, ninth;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{1, 1, 1}; bits_seen = 0; phase = 0; wait_left = 0;
      in_xfer = 0; live_mode = 0; eat_fall = 0; said_nack = 0;
    end else begin
      fell   = (hist[2] == 1) && (hist[1] == 0);
      eighth = fell && !eat_fall && bits_seen == 7;
      ninth  = fell && !eat_fall && bits_seen == 8;
      if (start_det || stop_det) phase = 0;
      else if (phase == 0 && eighth && live_mode) phase = 1;
      else if (phase == 1 && flag_clr) begin
        phase = 2; wait_left = setup_cnt; said_nack = ack_sel;
      end else if (phase == 2) begin
        if (wait_left == 0) phase = 3; else wait_left = wait_left - 1;
      end else if (phase == 3 && ninth) phase = 0;
      if (start_det) begin bits_seen = 0; eat_fall = 1; end
      else if (stop_det) begin bits_seen = 0; eat_fall = 0; end
      else if (fell) begin
        if (eat_fall) eat_fall = 0;
        else bits_seen = (bits_seen == 8) ? 0 : bits_seen + 1;
      end
      if (!in_xfer) live_mode = mode_en;
      if (start_det) in_xfer = 1; else if (stop_det) in_xfer = 0;
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = scl_in;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Compare with the model on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(scl_drive_low == (phase == 1 || phase == 2), cur_req, "scl_drive_low",
          scl_drive_low, (phase == 1 || phase == 2));
      chk(sda_drive_low == ((phase >= 2) && !said_nack), cur_req, "sda_drive_low",
          sda_drive_low, ((phase >= 2) && !said_nack));
      chk(ack_flag == (phase == 1), cur_req, "ack_flag", ack_flag, (phase == 1));
      if (scl_drive_low) stretch_seen++;
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  task automatic wait_high();
    while (!scl_in) @(negedge clk);
  endtask

  task automatic clock_bit();
    scl_mst = 1'b1; wait_high();
    repeat (4) @(negedge clk);
    scl_mst = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_start();
    scl_mst = 1'b1; wait_high();
    repeat (3) @(negedge clk);
    start_det = 1'b1; @(negedge clk); start_det = 1'b0;
    repeat (2) @(negedge clk);
    scl_mst = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_stop();
    scl_mst = 1'b1; wait_high();
    repeat (2) @(negedge clk);
    stop_det = 1'b1; @(negedge clk); stop_det = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_bits(input int n);
    for (int i = 0; i < n; i++) clock_bit();
  endtask

  // Software answer: clear the flag, measure the stretch, run the ack clock.
  task automatic answer(input bit nack, input int setup);
    int held;
    setup_cnt = setup[7:0];
    ack_sel = nack; flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk(ack_flag == 1'b0, "R4", "flag after clear", ack_flag, 0);
    chk(sda_drive_low == !nack, "R4", "ack level", sda_drive_low, !nack);
    ack_sel = !nack;  // later change must not matter (R10)
    held = 0;
    while (scl_drive_low && held < 300) begin held++; @(negedge clk); end
    chk(held == setup + 1, "R4", "stretch cycles after clear", held, setup + 1);
    chk(sda_drive_low == !nack, "R10", "ack level kept", sda_drive_low, !nack);
    clock_bit();
    chk(sda_drive_low == 1'b0, "R5", "data freed after ack pulse", sda_drive_low, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_drive_low && !sda_drive_low && !ack_flag, "R1", "outputs after reset",
        {scl_drive_low, sda_drive_low, ack_flag}, 0);

    // Main stretch and release, ACK then NACK with zero setup.
    cur_req = "R2"; mode_en = 1'b1;
    do_start(); send_bits(8);
    chk(ack_flag == 1'b1, "R2", "flag on eighth fall", ack_flag, 1);
    chk(scl_drive_low == 1'b1, "R2", "clock stretched", scl_drive_low, 1);
    cur_req = "R3";
    repeat (40) @(negedge clk);
    chk(ack_flag && scl_drive_low && !sda_drive_low, "R3", "long hold",
        {ack_flag, scl_drive_low, sda_drive_low}, 6);
    cur_req = "R4"; answer(1'b0, 5);
    cur_req = "R5"; send_bits(8);
    chk(ack_flag == 1'b1, "R5", "second byte stretches", ack_flag, 1);
    cur_req = "R10"; answer(1'b1, 0);
    do_stop();

    // Stray clear while idle.
    cur_req = "R6";
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    repeat (2) @(negedge clk);
    chk(!ack_flag && !scl_drive_low && !sda_drive_low, "R6", "stray clear",
        {ack_flag, scl_drive_low, sda_drive_low}, 0);
    do_start(); send_bits(8);
    chk(ack_flag == 1'b1, "R6", "stretch after stray clear", ack_flag, 1);
    answer(1'b0, 2); do_stop();

    // Mode changes inside a transfer act at the next one.
    cur_req = "R8"; mode_en = 1'b0;
    do_start(); send_bits(3); mode_en = 1'b1; send_bits(5);
    chk(ack_flag == 1'b0, "R8", "enable mid-transfer ignored", ack_flag, 0);
    clock_bit(); send_bits(8);
    chk(ack_flag == 1'b0, "R8", "still off in same transfer", ack_flag, 0);
    clock_bit(); do_stop();
    do_start(); send_bits(8);
    chk(ack_flag == 1'b1, "R8", "enable applied next transfer", ack_flag, 1);
    mode_en = 1'b0; answer(1'b0, 1); send_bits(8);
    chk(ack_flag == 1'b1, "R8", "disable mid-transfer ignored", ack_flag, 1);
    answer(1'b1, 1); do_stop();

    // Mode off: never stretch.
    cur_req = "R7"; stretch_seen = 0;
    do_start(); send_bits(8); clock_bit(); send_bits(8); clock_bit(); do_stop();
    chk(stretch_seen == 0, "R7", "stretch cycles with mode off", stretch_seen, 0);
    chk(ack_flag == 1'b0, "R7", "flag with mode off", ack_flag, 0);

    // Restart clears the count; stop beats a simultaneous clear.
    cur_req = "R9"; mode_en = 1'b1; @(negedge clk);
    do_start(); send_bits(3);
    do_start(); send_bits(7);
    chk(ack_flag == 1'b0, "R9", "no flag after 7 bits past restart", ack_flag, 0);
    send_bits(1);
    chk(ack_flag == 1'b1, "R9", "flag after 8 bits past restart", ack_flag, 1);
    ack_sel = 1'b0; stop_det = 1'b1; flag_clr = 1'b1;
    @(negedge clk); stop_det = 1'b0; flag_clr = 1'b0;
    chk(!ack_flag && !scl_drive_low && !sda_drive_low, "R9", "stop wins over clear",
        {ack_flag, scl_drive_low, sda_drive_low}, 0);
    repeat (10) @(negedge clk);
    chk(!scl_drive_low && !sda_drive_low, "R9", "lines stay free",
        {scl_drive_low, sda_drive_low}, 0);
    scl_mst = 1'b1;
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule